// File: doc/BRIEF.md
# Programmable Vertical Partial-Sum Adder

This block sits behind an 11 x 11 array of multiplying elements. On every cycle it receives one signed 16-bit product from each element. For each array column it forms up to three sums, each over a run of vertically adjacent rows. A downstream accumulator then combines these column sums across columns and across cycles into complete convolution outputs.

Each column owns three seven-input adders. A routing stage sits in front of every adder. It selects the rows of the configured run and steers them onto the adder lanes, and it forces every unused lane to zero. Each column is configured with one run length and three starting rows, one per adder, plus one enable bit per adder. The run length is the vertical extent of the filter segment mapped onto that column. A run length of up to seven is summed in one adder. Longer filters are covered by placing several shorter runs and combining them downstream. Every sum leaves the block in a register, together with a valid flag.

Top module: `vsum_array`

## Requirements
- R1: An enabled adder with a legal setting, whose input cycle has `prod_valid_i` high, outputs one cycle later the signed sum of the products of rows start through start+len-1 of its column, with its valid bit high.
- R2: Each column uses only its own products and its own length, start and enable fields. Different columns may carry different settings in the same cycle.
- R3: Sums are 32-bit two's complement and exact for seven terms at both extremes. Seven products of -32768 give -229376, and seven of 32767 give 229369.
- R4: A setting is legal only when 1 <= len <= 7 and start+len <= 11. On an illegal setting the adder outputs valid low and a sum of zero on the following cycle.
- R5: An adder whose enable bit is 0 outputs valid low and a sum of zero on the following cycle. A sum of zero always goes with valid low.
- R6: When `prod_valid_i` is low, every adder outputs valid low and a sum of zero on the following cycle.
- R7: While `rst_ni` is low, and immediately on its fall, every valid bit is low and every sum is zero.
- R8: Adders in one column may cover overlapping or identical rows. Each one returns the full sum of its own run.
- R9: Field positions are as follows. The product for column c, row r is at `prod_i[(c*11+r)*16 +: 16]`. The length for column c is at `cfg_len_i[c*4 +: 4]`. The start for adder a of column c is at `cfg_start_i[(c*3+a)*4 +: 4]`, and its enable bit is `cfg_en_i[c*3+a]`. Its sum is at `psum_o[(c*3+a)*32 +: 32]` and its flag is at `psum_valid_o[c*3+a]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prod_valid_i | input | 1 | Products on `prod_i` are valid this cycle |
| prod_i | input | 1936 | 121 signed 16-bit products, column-major |
| cfg_len_i | input | 44 | Run length per column, 4 bits each |
| cfg_start_i | input | 132 | Start row per adder, 4 bits each |
| cfg_en_i | input | 33 | Enable per adder |
| psum_o | output | 1056 | 33 signed 32-bit partial sums |
| psum_valid_o | output | 33 | Valid flag per partial sum |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produced it. This holds for the sums, the valid flags, the illegal and disabled cases and the idle case. The one exception is reset, which clears the outputs at once, with no edge needed. The bench drives each stimulus on a falling edge, lets one rising edge capture it, and compares all 33 outputs on the next falling edge. It recomputes each expected sum from the row formula and the legality rule. Reset is checked both while it is held and a moment after an asynchronous fall in the middle of a run.

// File: rtl/vsum_pkg.sv
package vsum_pkg;
  localparam int COLS   = 11;
  localparam int ROWS   = 11;
  localparam int ADDERS = 3;
  localparam int LANES  = 7;
  localparam int PROD_W = 16;
  localparam int SUM_W  = 32;
  localparam int ROW_W  = $clog2(ROWS + 1);
endpackage

// File: rtl/vsum_lane_mux.sv
module vsum_lane_mux #(
  parameter int ROWS   = vsum_pkg::ROWS,
  parameter int LANES  = vsum_pkg::LANES,
  parameter int PROD_W = vsum_pkg::PROD_W,
  parameter int ROW_W  = vsum_pkg::ROW_W
) (
  input  logic [ROWS*PROD_W-1:0]  col_prod_i,
  input  logic [ROW_W-1:0]        start_i,
  input  logic [ROW_W-1:0]        len_i,
  output logic [LANES*PROD_W-1:0] lanes_o
);
  // lane l carries row start+l when l < len, zero otherwise
  always_comb begin
    lanes_o = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int r = 0; r < ROWS; r++) begin
        if ((l < int'(len_i)) && (int'(start_i) + l == r))
          lanes_o[l*PROD_W +: PROD_W] = col_prod_i[r*PROD_W +: PROD_W];
      end
    end
  end
endmodule

// File: rtl/vsum_adder.sv
module vsum_adder #(
  parameter int LANES  = vsum_pkg::LANES,
  parameter int PROD_W = vsum_pkg::PROD_W,
  parameter int SUM_W  = vsum_pkg::SUM_W
) (
  input  logic [LANES*PROD_W-1:0] lanes_i,
  output logic [SUM_W-1:0]        sum_o
);
  always_comb begin
    sum_o = '0;
    for (int l = 0; l < LANES; l++)
      sum_o = sum_o + {{(SUM_W-PROD_W){lanes_i[l*PROD_W+PROD_W-1]}},
                       lanes_i[l*PROD_W +: PROD_W]};
  end
endmodule

// File: rtl/vsum_column.sv
module vsum_column #(
  parameter int ROWS   = vsum_pkg::ROWS,
  parameter int ADDERS = vsum_pkg::ADDERS,
  parameter int LANES  = vsum_pkg::LANES,
  parameter int PROD_W = vsum_pkg::PROD_W,
  parameter int SUM_W  = vsum_pkg::SUM_W,
  parameter int ROW_W  = vsum_pkg::ROW_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [ROWS*PROD_W-1:0]  col_prod_i,
  input  logic [ROW_W-1:0]        len_i,
  input  logic [ADDERS*ROW_W-1:0] starts_i,
  input  logic [ADDERS-1:0]       en_i,
  output logic [ADDERS*SUM_W-1:0] psum_o,
  output logic [ADDERS-1:0]       psum_valid_o
);
  for (genvar a = 0; a < ADDERS; a++) begin : g_adder
    logic [ROW_W-1:0]        start;
    logic                    legal;
    logic                    fire;
    logic [LANES*PROD_W-1:0] lanes;
    logic [SUM_W-1:0]        sum_d;
    logic [SUM_W-1:0]        sum_q;
    logic                    vld_q;

    assign start = starts_i[a*ROW_W +: ROW_W];
    // run must be 1..LANES rows and end inside the column
    assign legal = (len_i != '0) && (int'(len_i) <= LANES)
                && (int'(start) + int'(len_i) <= ROWS);
    assign fire  = valid_i & en_i[a] & legal;

    vsum_lane_mux #(
      .ROWS(ROWS), .LANES(LANES), .PROD_W(PROD_W), .ROW_W(ROW_W)
    ) u_mux (
      .col_prod_i(col_prod_i),
      .start_i   (start),
      .len_i     (len_i),
      .lanes_o   (lanes)
    );

    vsum_adder #(
      .LANES(LANES), .PROD_W(PROD_W), .SUM_W(SUM_W)
    ) u_add (
      .lanes_i(lanes),
      .sum_o  (sum_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= fire;
        sum_q <= fire ? sum_d : '0;
      end
    end

    assign psum_o[a*SUM_W +: SUM_W] = sum_q;
    assign psum_valid_o[a]          = vld_q;
  end
endmodule

// File: rtl/vsum_array.sv
module vsum_array #(
  parameter int COLS   = vsum_pkg::COLS,
  parameter int ROWS   = vsum_pkg::ROWS,
  parameter int ADDERS = vsum_pkg::ADDERS,
  parameter int LANES  = vsum_pkg::LANES,
  parameter int PROD_W = vsum_pkg::PROD_W,
  parameter int SUM_W  = vsum_pkg::SUM_W,
  parameter int ROW_W  = vsum_pkg::ROW_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         prod_valid_i,
  input  logic [COLS*ROWS*PROD_W-1:0]  prod_i,
  input  logic [COLS*ROW_W-1:0]        cfg_len_i,
  input  logic [COLS*ADDERS*ROW_W-1:0] cfg_start_i,
  input  logic [COLS*ADDERS-1:0]       cfg_en_i,
  output logic [COLS*ADDERS*SUM_W-1:0] psum_o,
  output logic [COLS*ADDERS-1:0]       psum_valid_o
);
  localparam int COL_PW = ROWS * PROD_W;
  localparam int COL_SW = ADDERS * ROW_W;
  localparam int COL_OW = ADDERS * SUM_W;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    vsum_column #(
      .ROWS(ROWS), .ADDERS(ADDERS), .LANES(LANES),
      .PROD_W(PROD_W), .SUM_W(SUM_W), .ROW_W(ROW_W)
    ) u_col (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (prod_valid_i),
      .col_prod_i  (prod_i[c*COL_PW +: COL_PW]),
      .len_i       (cfg_len_i[c*ROW_W +: ROW_W]),
      .starts_i    (cfg_start_i[c*COL_SW +: COL_SW]),
      .en_i        (cfg_en_i[c*ADDERS +: ADDERS]),
      .psum_o      (psum_o[c*COL_OW +: COL_OW]),
      .psum_valid_o(psum_valid_o[c*ADDERS +: ADDERS])
    );
  end
endmodule

// File: rtl/vsum_array_chk.sv
module vsum_array_chk #(
  parameter int COLS   = vsum_pkg::COLS,
  parameter int ROWS   = vsum_pkg::ROWS,
  parameter int ADDERS = vsum_pkg::ADDERS,
  parameter int LANES  = vsum_pkg::LANES,
  parameter int PROD_W = vsum_pkg::PROD_W,
  parameter int SUM_W  = vsum_pkg::SUM_W,
  parameter int ROW_W  = vsum_pkg::ROW_W
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         prod_valid_i,
  input logic [COLS*ROW_W-1:0]        cfg_len_i,
  input logic [COLS*ADDERS*ROW_W-1:0] cfg_start_i,
  input logic [COLS*ADDERS-1:0]       cfg_en_i,
  input logic [COLS*ADDERS*SUM_W-1:0] psum_o,
  input logic [COLS*ADDERS-1:0]       psum_valid_o
);
  localparam longint MAX_S = longint'(LANES) * ((longint'(1) << (PROD_W-1)) - 1);
  localparam longint MIN_S = -(longint'(LANES) * (longint'(1) << (PROD_W-1)));

  for (genvar c = 0; c < COLS; c++) begin : g_c
    for (genvar a = 0; a < ADDERS; a++) begin : g_a
      localparam int IDX = c*ADDERS + a;
      logic [ROW_W-1:0] len, st;
      logic [SUM_W-1:0] s;
      logic             bad_cfg;
      assign len = cfg_len_i[c*ROW_W +: ROW_W];
      assign st  = cfg_start_i[IDX*ROW_W +: ROW_W];
      assign s   = psum_o[IDX*SUM_W +: SUM_W];
      assign bad_cfg = (len == '0) || (int'(len) > LANES) || (int'(st) + int'(len) > ROWS);

      p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        psum_valid_o[IDX] |-> (longint'($signed(s)) <= MAX_S && longint'($signed(s)) >= MIN_S));
      p_illegal_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_cfg |=> !psum_valid_o[IDX]);
      p_disabled_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_en_i[IDX] |=> !psum_valid_o[IDX]);
      p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !psum_valid_o[IDX] |-> (s == '0));
      p_needs_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        psum_valid_o[IDX] |-> $past(prod_valid_i));
    end
  end
endmodule

bind vsum_array vsum_array_chk #(
  .COLS(COLS), .ROWS(ROWS), .ADDERS(ADDERS), .LANES(LANES),
  .PROD_W(PROD_W), .SUM_W(SUM_W), .ROW_W(ROW_W)
) u_chk (.*);

// File: tb/vsum_array_bench.sv
`timescale 1ns/1ps
module vsum_array_bench;
  localparam int COLS = 11, ROWS = 11, ADDERS = 3, PW = 16, SW = 32, RW = 4;
  localparam int NV = 10;
  // seed, len, three base starts (start = base + c%3), enable mask, input valid
  localparam int V_SEED [NV] = '{3, 4, 5, 1, 2, 6, 7, 8, 9, 10};
  localparam int V_LEN  [NV] = '{3, 4, 7, 7, 7, 8, 0, 1, 5, 3};
  localparam int V_S0   [NV] = '{0, 0, 0, 0, 0, 0, 0, 8, 2, 0};
  localparam int V_S1   [NV] = '{3, 4, 2, 0, 1, 1, 1, 5, 2, 1};
  localparam int V_S2   [NV] = '{6, 7, 4, 4, 2, 2, 2, 0, 6, 2};
  localparam int V_EN   [NV] = '{7, 7, 7, 7, 7, 7, 7, 5, 6, 7};
  localparam int V_VLD  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0};

  logic                        clk_i = 1'b0;
  logic                        rst_ni = 1'b0;
  logic                        prod_valid_i = 1'b0;
  logic [COLS*ROWS*PW-1:0]     prod_i = '0;
  logic [COLS*RW-1:0]          cfg_len_i = '0;
  logic [COLS*ADDERS*RW-1:0]   cfg_start_i = '0;
  logic [COLS*ADDERS-1:0]      cfg_en_i = '0;
  logic [COLS*ADDERS*SW-1:0]   psum_o;
  logic [COLS*ADDERS-1:0]      psum_valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  vsum_array u_vsum_array (.*);

  function automatic logic signed [15:0] pval(int seed, int c, int r);
    logic [31:0] t;
    if (seed == 1) return 16'sh8000;
    if (seed == 2) return 16'sh7fff;
    t = 32'((c*37 + r*101 + seed*53) * 97 + seed*1231);
    return t[15:0];
  endfunction

  function automatic int start_of(int v, int c, int a);
    int b;
    b = (a == 0) ? V_S0[v] : (a == 1) ? V_S1[v] : V_S2[v];
    return (b + c % 3) % 16;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // R9: field positions used when packing inputs and unpacking outputs
  task automatic drive(int v);
    prod_valid_i = V_VLD[v][0];
    for (int c = 0; c < COLS; c++) begin
      cfg_len_i[c*RW +: RW] = RW'(V_LEN[v]);
      for (int r = 0; r < ROWS; r++) prod_i[(c*ROWS+r)*PW +: PW] = pval(V_SEED[v], c, r);
      for (int a = 0; a < ADDERS; a++) begin
        cfg_start_i[(c*ADDERS+a)*RW +: RW] = RW'(start_of(v, c, a));
        cfg_en_i[c*ADDERS+a] = V_EN[v][a];
      end
    end
  endtask

  task automatic check_vec(int v);
    for (int c = 0; c < COLS; c++) begin
      for (int a = 0; a < ADDERS; a++) begin
        int st, ln, es, ev, as;
        bit legal, en;
        string tag;
        st = start_of(v, c, a);
        ln = V_LEN[v];
        legal = (ln >= 1) && (ln <= 7) && (st + ln <= ROWS);
        en = V_EN[v][a];
        es = 0;
        ev = (V_VLD[v] != 0 && en && legal) ? 1 : 0;
        if (ev == 1) for (int r = st; r < st + ln; r++) es += int'(pval(V_SEED[v], c, r));
        if (V_VLD[v] == 0) tag = "R6";
        else if (!en) tag = "R5";
        else if (!legal) tag = "R4";
        else if (V_SEED[v] <= 2) tag = "R3";
        else if (v == 3 && a < 2) tag = "R8";
        else if (v == 1) tag = "R2";
        else tag = "R1";
        as = $signed(psum_o[(c*ADDERS+a)*SW +: SW]);
        chk(tag, $sformatf("vec%0d col%0d add%0d valid", v, c, a),
            int'(psum_valid_o[c*ADDERS+a]), ev);
        chk(tag, $sformatf("vec%0d col%0d add%0d sum", v, c, a), as, es);
      end
    end
  endtask

  initial begin
    #4000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R7: outputs cleared while reset held
    chk("R7", "valid in reset", int'(psum_valid_o != '0), 0);
    chk("R7", "sum in reset", int'(psum_o != '0), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int v = 0; v < NV; v++) begin
      drive(v);
      @(negedge clk_i);
      check_vec(v);
    end
    // R1: results follow each new input on the very next edge, back to back
    drive(0);
    @(negedge clk_i);
    drive(3);
    @(negedge clk_i);
    check_vec(3);
    // R7: asynchronous reset mid-run clears at once
    drive(2);
    @(negedge clk_i);
    chk("R1", "valid before reset", int'(psum_valid_o[0]), 1);
    #3 rst_ni = 1'b0;
    #1;
    chk("R7", "valid after async reset", int'(psum_valid_o != '0), 0);
    chk("R7", "sum after async reset", int'(psum_o != '0), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(4);
    @(negedge clk_i);
    check_vec(4);
    finish_run();
  end
endmodule